// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. The frame shape comes from an 8-bit frame-control input:
- the number of data bits;
- whether a parity bit is sent, and how it is formed;
- the length of the stop period;
- a forced break.

Bytes arrive over a valid/ready handshake. Each byte lands in a one-word holding register. From there it moves into a shift engine as soon as the engine is free.

Timing comes from a baud tick pulse at sixteen times the bit rate. Every bit lasts sixteen ticks. The stop period lasts 16, 24 or 32 ticks.

Two flags report progress. The hold-empty flag says another byte can be taken. The transmit-empty flag says nothing is held and nothing is being sent.

The frame format is captured when a byte enters the shift engine. Software should change the format only while the transmit-empty flag is set. The break bit is the one exception: it acts at once, in whatever cycle it changes.

Top module: `serial_frame_tx`

## Requirements
- R1: The line idles at 1. A frame starts with one start bit at 0. The data bits follow, least significant first. Frame-control bits 1:0 choose how many data bits are sent: 0→5, 1→6, 2→7, 3→8. Each bit lasts 16 baud ticks.
- R2: With frame-control bit 2 at 0, the stop period is one bit (16 ticks) at level 1. With bit 2 at 1, it is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R3: With frame-control bit 3 at 1, one parity bit of 16 ticks is sent between the last data bit and the stop period. With bit 3 at 0, no parity bit is sent.
- R4: With parity on and bit 5 at 0, bit 4 chooses the parity. With bit 4 at 1, the parity bit equals the XOR of the sent data bits (even parity). With bit 4 at 0, it is the inverse of that XOR (odd parity).
- R5: With parity on and bit 5 at 1, the parity bit is a constant equal to the inverse of bit 4. Control value 0x38 sends 0 and 0x28 sends 1.
- R6: While frame-control bit 6 is 1, the line is at 0 in the same cycle, whatever the transmitter is doing.
- R7: Setting bit 6 cancels any frame in progress. The rest of that character is never sent. While bit 6 stays at 1, no held byte enters the shift engine. After bit 6 clears, the line goes back to 1 at once, and any held byte is then sent as a complete frame.
- R8: `in_ready` is the same as hold-empty. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Hold-empty drops in the cycle after that edge. Hold-empty rises again in the cycle after the byte enters the shift engine, even though the engine is still sending it.
- R9: Transmit-empty is 1 only when the holding register is empty and the shift engine is idle. It stays at 0 until the stop period of the last queued byte has ended.
- R10: After reset, the line is at 1 and hold-empty, transmit-empty and `in_ready` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| frame_ctl | input | 8 | Frame format and break control |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding register can accept a byte |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register is empty |
| xmit_empty | output | 1 | Holding register and shift engine are both idle |

## Verification
Each frame on the line is decoded one tick at a time and compared with a frame model that the bench computes on its own. A sweep over all word lengths with both stop settings separates the 16-, 24- and 32-tick stop periods. A pass over the four parity encodings, using data of odd and even weight, separates even, odd, mark and space parity. Random control values with back-to-back bursts of three bytes show whether the holding register hands over a byte without a gap and keeps the format captured at load. Directed sequences cover the flag timing and a break raised in the middle of a character, with a byte waiting in the holding register; this shows whether the cut-off character is dropped and the waiting byte is sent in full.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  localparam int unsigned WORD_MAX = 8;

  // frame-control field positions
  localparam int unsigned FC_STOP  = 2;
  localparam int unsigned FC_PEN   = 3;
  localparam int unsigned FC_EVEN  = 4;
  localparam int unsigned FC_STICK = 5;
  localparam int unsigned FC_BRK   = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // number of data bits, 5..8
  function automatic logic [3:0] word_len(input logic [7:0] ctl);
    return 4'd5 + {2'b00, ctl[1:0]};
  endfunction

  // stop period measured in oversample ticks
  function automatic int unsigned stop_ticks(input logic [7:0] ctl,
                                             input int unsigned ovs);
    if (!ctl[FC_STOP])      return ovs;
    else if (ctl[1:0] == 2'b00) return ovs + ovs / 2;
    else                    return 2 * ovs;
  endfunction

  // value of the parity slot for a given word and format
  function automatic logic parity_bit(input logic [7:0] ctl,
                                      input logic [WORD_MAX-1:0] data);
    logic [WORD_MAX-1:0] kept;
    kept = data & ~(8'hFF << word_len(ctl));
    if (ctl[FC_STICK]) return ~ctl[FC_EVEN];
    return (^kept) ^ ~ctl[FC_EVEN];
  endfunction

endpackage

// File: rtl/sftx_hold.sv
module sftx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      rd_data <= '0;
    end else if (wr_valid && !full) begin
      full    <= 1'b1;
      rd_data <= wr_data;
    end else if (take) begin
      full    <= 1'b0;
    end
  end

  assign wr_ready = !full;

endmodule

// File: rtl/sftx_engine.sv
module sftx_engine
  import sftx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [7:0]          ctl,
  input  logic                hold_full,
  input  logic [WORD_MAX-1:0] hold_data,
  output logic                load,
  output logic                busy,
  output logic                line
);

  localparam int unsigned CNT_W = $clog2(2 * OVS + 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);

  tx_state_e           state;
  logic [CNT_W-1:0]    cnt;
  logic [2:0]          idx;
  logic [WORD_MAX-1:0] shreg;
  logic [3:0]          nbits;
  logic                par_en;
  logic                par_val;
  logic [CNT_W-1:0]    stop_len;

  logic brk;
  logic bit_done;
  logic last_data;
  logic unused_ctl7;

  assign brk         = ctl[FC_BRK];
  assign unused_ctl7 = ctl[7];
  assign bit_done    = (cnt == BIT_LAST);
  assign last_data   = ({1'b0, idx} == nbits - 4'd1);
  assign load        = (state == ST_IDLE) && hold_full && !brk;
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      nbits    <= 4'd8;
      par_en   <= 1'b0;
      par_val  <= 1'b0;
      stop_len <= CNT_W'(OVS);
    end else if (brk) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (load) begin
      state    <= ST_START;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= hold_data;
      nbits    <= word_len(ctl);
      par_en   <= ctl[FC_PEN];
      par_val  <= parity_bit(ctl, hold_data);
      stop_len <= CNT_W'(stop_ticks(ctl, OVS));
    end else if (tick && busy) begin
      unique case (state)
        ST_START: begin
          if (bit_done) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_done) begin
            cnt   <= '0;
            shreg <= shreg >> 1;
            idx   <= idx + 3'd1;
            if (last_data) state <= par_en ? ST_PAR : ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bit_done) begin
            state <= ST_STOP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == stop_len - 1'b1) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // line level follows registered state; break forces spacing
  always_comb begin
    unique case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = par_val;
      default:  line = 1'b1;
    endcase
    if (brk) line = 1'b0;
  end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [7:0] frame_ctl,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       txd,
  output logic       hold_empty,
  output logic       xmit_empty
);

  logic                hold_full;
  logic [WORD_MAX-1:0] hold_data;
  logic                load_pulse;
  logic                eng_busy;

  sftx_hold #(.DW(WORD_MAX)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (in_valid),
    .wr_ready (in_ready),
    .wr_data  (in_data),
    .take     (load_pulse),
    .full     (hold_full),
    .rd_data  (hold_data)
  );

  sftx_engine #(.OVS(OVS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .ctl       (frame_ctl),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .load      (load_pulse),
    .busy      (eng_busy),
    .line      (txd)
  );

  assign hold_empty = !hold_full;
  assign xmit_empty = !hold_full && !eng_busy;

endmodule

// File: rtl/sftx_checker.sv
module sftx_checker (
  input logic clk,
  input logic rst_n,
  input logic break_req,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic hold_empty,
  input logic xmit_empty,
  input logic load_pulse,
  input logic eng_busy
);

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && !break_req) |-> txd);

  assert_start_space_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> !txd);

  assert_break_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
    break_req |-> !txd);

  assert_break_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    break_req |=> !eng_busy);

  assert_hold_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !hold_empty);

  assert_load_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> (hold_empty && eng_busy));

  assert_empty_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_empty |-> (hold_empty && !eng_busy));

endmodule

bind serial_frame_tx sftx_checker u_sftx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .break_req  (frame_ctl[6]),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .txd        (txd),
  .hold_empty (hold_empty),
  .xmit_empty (xmit_empty),
  .load_pulse (load_pulse),
  .eng_busy   (eng_busy)
);

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic [7:0] frame_ctl;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_ready;
  logic       txd;
  logic       hold_empty;
  logic       xmit_empty;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] expq[$];
  bit          mon_en   = 1'b0;
  bit          in_frame = 1'b0;
  bit          done     = 1'b0;

  always #4 clk = ~clk;

  serial_frame_tx i_serial_frame_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .frame_ctl  (frame_ctl),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .txd        (txd),
    .hold_empty (hold_empty),
    .xmit_empty (xmit_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---- bench model of a frame ----
  function automatic int n_data(input logic [7:0] c);
    case (c[1:0])
      2'd0: return 5;
      2'd1: return 6;
      2'd2: return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic par_model(input logic [7:0] c, input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < n_data(c); i++) ones += d[i];
    if (c[5]) return c[4] ? 1'b0 : 1'b1;      // space / mark
    if (c[4]) return (ones % 2) == 1;          // even
    return (ones % 2) == 0;                    // odd
  endfunction

  function automatic int frame_len(input logic [7:0] c);
    int stop;
    if (!c[2])              stop = 16;
    else if (n_data(c) == 5) stop = 24;
    else                    stop = 32;
    return 16 * (1 + n_data(c) + (c[3] ? 1 : 0)) + stop;
  endfunction

  function automatic logic level_at(input logic [7:0] c, input logic [7:0] d,
                                    input int t);
    int slot = t / 16;
    if (slot == 0) return 1'b0;
    if (slot <= n_data(c)) return d[slot-1];
    if (c[3] && slot == n_data(c) + 1) return par_model(c, d);
    return 1'b1;
  endfunction

  function automatic string tag_of(input logic [7:0] c);
    if (c[3] && c[5]) return "R5";
    if (c[3])         return "R4";
    if (c[2])         return "R2";
    return "R1";
  endfunction

  // ---- baud tick source: one pulse every 4 cycles ----
  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  // ---- line monitor: samples txd at every tick ----
  initial begin
    logic [15:0] cur;
    int   t;
    int   bad_t;
    logic bad_v;
    forever begin
      @(negedge clk);
      #1;
      if (!mon_en) begin
        in_frame = 1'b0;
        continue;
      end
      if (!baud_tick) continue;
      if (!in_frame && txd == 1'b0) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R1", "unexpected start bit", 0, 1);
          continue;
        end
        cur = expq.pop_front();
        in_frame = 1'b1;
        t = 0;
        bad_t = -1;
        bad_v = 1'b0;
      end
      if (in_frame) begin
        if (txd !== level_at(cur[15:8], cur[7:0], t) && bad_t < 0) begin
          bad_t = t;
          bad_v = txd;
        end
        t++;
        if (t == frame_len(cur[15:8])) begin
          in_frame = 1'b0;
          if (bad_t >= 0)
            $display("  frame ctl=%h data=%h first mismatch at tick %0d",
                     cur[15:8], cur[7:0], bad_t);
          chk(bad_t < 0, tag_of(cur[15:8]), "frame waveform",
              bad_t < 0 ? 0 : bad_v,
              bad_t < 0 ? 0 : level_at(cur[15:8], cur[7:0], bad_t));
        end
      end
    end
  end

  // ---- stimulus helpers ----
  task automatic send(input logic [7:0] d, input logic [7:0] c, input bit push);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (push) expq.push_back({c, d});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain;
    do begin
      @(negedge clk);
      #1;
    end while (!(xmit_empty && !in_frame));
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    frame_ctl = c;
    send(d, c, 1'b1);
    drain();
  endtask

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // ---- main sequence ----
  initial begin
    logic [7:0] c;
    void'($urandom(32'h5EED_0C7A));
    rst_n     = 1'b0;
    frame_ctl = 8'h03;
    in_data   = 8'h00;
    in_valid  = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk(txd == 1'b1,        "R10", "txd in reset",        txd, 1);
    chk(hold_empty == 1'b1, "R10", "hold_empty in reset", hold_empty, 1);
    chk(xmit_empty == 1'b1, "R10", "xmit_empty in reset", xmit_empty, 1);
    chk(in_ready == 1'b1,   "R10", "in_ready in reset",   in_ready, 1);
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3: every word length, both stop settings, no parity
    for (int w = 0; w < 4; w++) begin
      frame(8'(w), 8'hB5);
      frame(8'(w | 4), 8'h4E);
    end

    // R4 R5: four parity encodings on odd- and even-weight data
    frame(8'h0B, 8'h07);   // odd parity, 8 bits
    frame(8'h1B, 8'h07);   // even parity
    frame(8'h0A, 8'h33);
    frame(8'h1A, 8'h33);
    frame(8'h2B, 8'h00);   // mark
    frame(8'h3B, 8'hFF);   // space
    frame(8'h28, 8'h15);
    frame(8'h3C, 8'h1E);   // space, 5 bits, 1.5 stop

    // random formats, bursts of three bytes
    for (int g = 0; g < 18; g++) begin
      c = 8'($urandom) & 8'hBF;
      @(negedge clk);
      frame_ctl = c;
      for (int k = 0; k < 3; k++) send(8'($urandom), c, 1'b1);
      drain();
    end

    // R8 R9: flag timing around acceptance and handover
    @(negedge clk);
    frame_ctl = 8'h03;
    send(8'h5A, 8'h03, 1'b1);
    #1;
    chk(hold_empty == 1'b0, "R8", "hold_empty after accept", hold_empty, 0);
    chk(xmit_empty == 1'b0, "R9", "xmit_empty after accept", xmit_empty, 0);
    @(negedge clk);
    #1;
    chk(hold_empty == 1'b1, "R8", "hold_empty after handover", hold_empty, 1);
    chk(xmit_empty == 1'b0, "R9", "xmit_empty while shifting", xmit_empty, 0);
    send(8'hC3, 8'h03, 1'b1);
    repeat (4) @(negedge clk);
    #1;
    chk(hold_empty == 1'b0 && in_ready == 1'b0, "R8", "second byte held",
        {hold_empty, in_ready}, 0);
    drain();
    chk(expq.size() == 0, "R9", "queued bytes left at transmit-empty",
        expq.size(), 0);

    // R6 R7: break in the middle of a character
    mon_en = 1'b0;
    @(negedge clk);
    frame_ctl = 8'h03;
    send(8'hFF, 8'h03, 1'b0);
    repeat (100) @(negedge clk);
    #1;
    chk(txd == 1'b1, "R1", "data bit of 0xFF mid-frame", txd, 1);
    @(negedge clk);
    frame_ctl = 8'h43;
    #1;
    chk(txd == 1'b0, "R6", "line on break", txd, 0);
    send(8'hA5, 8'h03, 1'b0);
    repeat (40) @(negedge clk);
    #1;
    chk(txd == 1'b0, "R6", "line held spacing", txd, 0);
    chk(hold_empty == 1'b0, "R7", "held byte not started during break",
        hold_empty, 0);
    chk(xmit_empty == 1'b0, "R9", "xmit_empty with byte held", xmit_empty, 0);
    @(negedge clk);
    expq.push_back({8'h03, 8'hA5});
    frame_ctl = 8'h03;
    mon_en    = 1'b1;
    #1;
    chk(txd == 1'b1, "R7", "line after break release", txd, 1);
    drain();
    chk(expq.size() == 0, "R7", "held byte sent after release",
        expq.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule